// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit turns an addressing-mode code, the operand bytes of an instruction and the two index registers of an 8-bit accumulator processor into the effective operand address. Direct modes (absolute, the indexed forms of absolute and zero page) are settled in a single step. The three pointer modes first have to fetch a two-byte pointer, so a small state machine reads it through a synchronous byte read port. Immediate mode returns the literal operand byte rather than an address. Modes that name no memory operand are flagged as invalid. The instruction length in bytes is derived from the mode code combinationally.

The sequencer issues a one-cycle `start` while the unit is idle. A single-cycle `done` pulse marks the cycle in which the result outputs are valid. The results then hold until the next `done`. A `start` seen while `busy` is high is ignored. The memory returns the byte for an address presented with `mem_rd` on the following cycle.

The machine has five states: IDLE, PTR_LO, PTR_HI, JOIN and FINISH.
- IDLE moves to FINISH on `start` with a direct, immediate or invalid mode.
- IDLE moves to PTR_LO on `start` with a pointer mode.
- PTR_LO (low pointer byte read) moves to PTR_HI (high pointer byte read).
- PTR_HI moves to JOIN, where the pointer is assembled and Y is added when the mode asks for it.
- JOIN moves to FINISH (`done`), which always returns to IDLE.

Top module: `ea_unit`

## Requirements
- R1: Mode codes are 1 absolute, 2 absolute+X, 3 absolute+Y, 4 accumulator, 5 immediate, 6 implied, 7 indirect, 8 (indirect,X), 9 (indirect),Y, 10 relative, 11 zero page, 12 zero page+X, 13 zero page+Y; any other code is unused. `inst_len` is 3 for codes 1, 2, 3 and 7; 2 for codes 5, 8, 9, 10, 11, 12 and 13; and 1 for codes 4 and 6 and for every unused code.
- R2: Codes 1, 2 and 3 give `{opnd_hi,opnd_lo}` plus 0, X or Y respectively, zero-extended, modulo 2^16. `done` rises the cycle after `start`, with no memory read.
- R3: Codes 11, 12 and 13 give the address `{8'h00, (opnd_lo + 0/X/Y) mod 256}`. `done` rises the cycle after `start`, with no memory read.
- R4: Code 5 sets `imm_valid`, puts `opnd_lo` on `imm_val` and drives `ea` to 0. `bad_mode` stays low, no memory read is made, and `done` rises the cycle after `start`.
- R5: Codes 4, 6 and 10 and the unused codes set `bad_mode` and clear `ea`, `imm_valid` and `imm_val`. No memory read is made, and `done` rises the cycle after `start`.
- R6: Code 7 reads the byte at `{opnd_hi,opnd_lo}` in the cycle after `start` and the byte at that address + 1 (16-bit wrap) in the next cycle. The result is `ea = {second byte, first byte}`, and `done` rises 4 cycles after `start`.
- R7: Code 8 uses the pointer address `{8'h00, (opnd_lo + X) mod 256}`, then follows the same read order and timing as R6. The second read goes to the pointer address + 1 with a 16-bit carry, so 0x00FF is followed by 0x0100.
- R8: Code 9 reads the pointer at `{8'h00, opnd_lo}` with the timing of R6, then gives `ea` = pointer + Y (Y as sampled at `start`) modulo 2^16.
- R9: `done` lasts exactly one cycle. `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` while `busy` is high has no effect. The result outputs change only at the edge that raises `done`.
- R10: During reset `busy`, `done`, `mem_rd`, `mem_addr`, `ea`, `imm_valid`, `imm_val` and `bad_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation (taken only when idle) |
| mode | input | 4 | Addressing-mode code |
| opnd_lo | input | DW | Operand byte 1 (low byte / zero-page address / literal) |
| opnd_hi | input | DW | Operand byte 2 (high byte of a 16-bit operand) |
| idx_x | input | DW | X index register |
| idx_y | input | DW | Y index register |
| mem_data | input | DW | Read data, valid one cycle after the request |
| mem_rd | output | 1 | Read request |
| mem_addr | output | AW | Read address |
| inst_len | output | 2 | Instruction length in bytes for `mode` |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| ea | output | AW | Effective address |
| imm_valid | output | 1 | Result is a literal operand |
| imm_val | output | DW | Literal operand value |
| bad_mode | output | 1 | Mode has no memory operand |

## Verification
The stimulus covers each mode with index values that do and do not cross a boundary. Absolute plus X stepping from 0x12FF to 0x1300 checks that the carry reaches the high byte. Zero page plus X from 0xF0 checks that the carry is dropped. The pointer cases include pointers at 0x00FF and 0xFFFF, which show whether the second read carries into the next page or wraps the full address space. The indirect-indexed case uses Y = 0xFF, which separates adding Y to the fetched pointer from adding it to the zero-page address. A `start` of a different mode is raised while a pointer fetch is in flight; the reference model, compared on every cycle, shows whether it corrupts the result or the read sequence.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_NONE = 4'd0,
        AM_ABS  = 4'd1,
        AM_ABX  = 4'd2,
        AM_ABY  = 4'd3,
        AM_ACC  = 4'd4,
        AM_IMM  = 4'd5,
        AM_IMP  = 4'd6,
        AM_IND  = 4'd7,
        AM_IZX  = 4'd8,
        AM_IZY  = 4'd9,
        AM_REL  = 4'd10,
        AM_ZP   = 4'd11,
        AM_ZPX  = 4'd12,
        AM_ZPY  = 4'd13
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PTR_LO = 3'd1,
        ST_PTR_HI = 3'd2,
        ST_JOIN   = 3'd3,
        ST_FINISH = 3'd4
    } ea_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       invalid;
        logic       imm;
        logic       indirect;
        logic       post_y;
    } mode_info_t;

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
    import ea_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_info_t        info
);
    always_comb begin
        info = '{len: 2'd1, invalid: 1'b1, imm: 1'b0, indirect: 1'b0, post_y: 1'b0};
        unique case (mode)
            AM_ABS, AM_ABX, AM_ABY: begin
                info.len     = 2'd3;
                info.invalid = 1'b0;
            end
            AM_IND: begin
                info.len      = 2'd3;
                info.invalid  = 1'b0;
                info.indirect = 1'b1;
            end
            AM_IZX: begin
                info.len      = 2'd2;
                info.invalid  = 1'b0;
                info.indirect = 1'b1;
            end
            AM_IZY: begin
                info.len      = 2'd2;
                info.invalid  = 1'b0;
                info.indirect = 1'b1;
                info.post_y   = 1'b1;
            end
            AM_IMM: begin
                info.len     = 2'd2;
                info.invalid = 1'b0;
                info.imm     = 1'b1;
            end
            AM_ZP, AM_ZPX, AM_ZPY: begin
                info.len     = 2'd2;
                info.invalid = 1'b0;
            end
            AM_REL: info.len = 2'd2;
            default: info.len = 2'd1;
        endcase
    end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2 * DW
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     opnd_lo,
    input  logic [DW-1:0]     opnd_hi,
    input  logic [DW-1:0]     idx_x,
    input  logic [DW-1:0]     idx_y,
    output logic [AW-1:0]     direct_addr,
    output logic [AW-1:0]     ptr_addr
);
    localparam logic [DW-1:0] PAGE0 = '0;

    logic [AW-1:0] wide_op;
    logic [DW-1:0] zp_x;
    logic [DW-1:0] zp_y;

    assign wide_op = {opnd_hi, opnd_lo};
    assign zp_x    = opnd_lo + idx_x;
    assign zp_y    = opnd_lo + idx_y;

    always_comb begin
        direct_addr = '0;
        unique case (mode)
            AM_ABS:  direct_addr = wide_op;
            AM_ABX:  direct_addr = wide_op + {PAGE0, idx_x};
            AM_ABY:  direct_addr = wide_op + {PAGE0, idx_y};
            AM_ZP:   direct_addr = {PAGE0, opnd_lo};
            AM_ZPX:  direct_addr = {PAGE0, zp_x};
            AM_ZPY:  direct_addr = {PAGE0, zp_y};
            default: direct_addr = '0;
        endcase
    end

    always_comb begin
        ptr_addr = '0;
        unique case (mode)
            AM_IND:  ptr_addr = wide_op;
            AM_IZX:  ptr_addr = {PAGE0, zp_x};
            AM_IZY:  ptr_addr = {PAGE0, opnd_lo};
            default: ptr_addr = '0;
        endcase
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     opnd_lo,
    input  logic [DW-1:0]     opnd_hi,
    input  logic [DW-1:0]     idx_x,
    input  logic [DW-1:0]     idx_y,
    input  logic [DW-1:0]     mem_data,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    output logic [1:0]        inst_len,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     ea,
    output logic              imm_valid,
    output logic [DW-1:0]     imm_val,
    output logic              bad_mode
);
    localparam logic [DW-1:0] ZERO_B = '0;

    mode_info_t    info;
    logic [AW-1:0] direct_w;
    logic [AW-1:0] ptr_w;

    ea_state_e     state_q, state_d;
    logic [AW-1:0] ptr_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] y_q;
    logic          post_y_q;
    logic [AW-1:0] ea_q;
    logic          immv_q;
    logic [DW-1:0] imm_q;
    logic          bad_q;

    ea_mode_dec u_dec (
        .mode (mode),
        .info (info)
    );

    ea_addr_calc #(.DW(DW), .AW(AW)) u_calc (
        .mode        (mode),
        .opnd_lo     (opnd_lo),
        .opnd_hi     (opnd_hi),
        .idx_x       (idx_x),
        .idx_y       (idx_y),
        .direct_addr (direct_w),
        .ptr_addr    (ptr_w)
    );

    assign inst_len = info.len;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = info.indirect ? ST_PTR_LO : ST_FINISH;
            ST_PTR_LO: state_d = ST_PTR_HI;
            ST_PTR_HI: state_d = ST_JOIN;
            ST_JOIN:   state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            lo_q     <= '0;
            y_q      <= '0;
            post_y_q <= 1'b0;
            ea_q     <= '0;
            immv_q   <= 1'b0;
            imm_q    <= '0;
            bad_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (info.indirect) begin
                            ptr_q    <= ptr_w;
                            y_q      <= idx_y;
                            post_y_q <= info.post_y;
                        end else begin
                            ea_q   <= (info.invalid || info.imm) ? '0 : direct_w;
                            bad_q  <= info.invalid;
                            immv_q <= info.imm;
                            imm_q  <= info.imm ? opnd_lo : '0;
                        end
                    end
                end
                ST_PTR_HI: lo_q <= mem_data;
                ST_JOIN: begin
                    ea_q   <= {mem_data, lo_q} + (post_y_q ? {ZERO_B, y_q} : '0);
                    bad_q  <= 1'b0;
                    immv_q <= 1'b0;
                    imm_q  <= '0;
                end
                default: ;
            endcase
        end
    end

    // state-decoded outputs
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        unique case (state_q)
            ST_PTR_LO: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_q;
            end
            ST_PTR_HI: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_q + 1'b1;
            end
            default: ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FINISH);
    assign ea        = ea_q;
    assign imm_valid = immv_q;
    assign imm_val   = imm_q;
    assign bad_mode  = bad_q;

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
    parameter int DW = 8,
    parameter int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    mode,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] ea,
    input logic          imm_valid,
    input logic          bad_mode
);
    logic take;
    assign take = start && !busy;

    // R9
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);
    // R10 / R9: idle means quiet
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !done));
    // R2 / R3 / R4 / R5: single-step modes finish without reading
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(mode inside {4'd7, 4'd8, 4'd9})) |=> (done && !mem_rd));
    // R5
    a_r5_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(mode inside {4'd1, 4'd2, 4'd3, 4'd5, 4'd7, 4'd8, 4'd9,
                                4'd11, 4'd12, 4'd13})) |=> bad_mode);
    // R6
    a_r6_ptr_start: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (mode inside {4'd7, 4'd8, 4'd9})) |=> (mem_rd && !done));
    // R6 / R7
    a_r6_second_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !$past(mem_rd)) |=> (mem_rd && mem_addr == $past(mem_addr) + 1'b1));
    // R6
    a_r6_two_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |=> !mem_rd);
    // R4
    a_r4_imm_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && imm_valid) |-> (!bad_mode && ea == '0));
    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(done) && busy) |-> $stable(ea));
endmodule

bind ea_unit ea_unit_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .done      (done),
    .ea        (ea),
    .imm_valid (imm_valid),
    .bad_mode  (bad_mode)
);

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
    logic [7:0]  mem_data = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [1:0]  inst_len;
    logic        busy, done, imm_valid, bad_mode;
    logic [15:0] ea;
    logic [7:0]  imm_val;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
        .mem_data(mem_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .inst_len(inst_len), .busy(busy), .done(done), .ea(ea),
        .imm_valid(imm_valid), .imm_val(imm_val), .bad_mode(bad_mode)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    always @(posedge clk) if (mem_rd) mem_data <= memf(mem_addr);

    function automatic string req_of(input int m);
        if (m >= 1 && m <= 3) return "R2";
        if (m >= 11 && m <= 13) return "R3";
        if (m == 5) return "R4";
        if (m == 7) return "R6";
        if (m == 8) return "R7";
        if (m == 9) return "R8";
        return "R5";
    endfunction

    function automatic int len_of(input int m);
        if (m inside {1, 2, 3, 7}) return 3;
        if (m inside {5, 8, 9, 10, 11, 12, 13}) return 2;
        return 1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // reference model
    int          ph = 0;
    string       cur_req = "R10";
    logic [15:0] e_ea = '0, e_ptr = '0, pend = '0;
    logic        e_immv = 0, e_bad = 0;
    logic [7:0]  e_imm = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; e_ea = '0; e_immv = 0; e_bad = 0; e_imm = '0;
        end else begin
            case (ph)
                0: if (start) begin
                    cur_req = req_of(int'(mode));
                    e_ptr = '0;
                    case (int'(mode))
                        7:  e_ptr = {opnd_hi, opnd_lo};
                        8:  e_ptr = {8'h00, 8'(opnd_lo + idx_x)};
                        9:  e_ptr = {8'h00, opnd_lo};
                        default: ;
                    endcase
                    if (mode inside {4'd7, 4'd8, 4'd9}) begin
                        pend = {memf(e_ptr + 16'd1), memf(e_ptr)};
                        if (mode == 4'd9) pend = pend + {8'h00, idx_y};
                        ph = 1;
                    end else begin
                        e_immv = 0; e_bad = 0; e_imm = '0; e_ea = '0;
                        case (int'(mode))
                            1:  e_ea = {opnd_hi, opnd_lo};
                            2:  e_ea = {opnd_hi, opnd_lo} + {8'h00, idx_x};
                            3:  e_ea = {opnd_hi, opnd_lo} + {8'h00, idx_y};
                            11: e_ea = {8'h00, opnd_lo};
                            12: e_ea = {8'h00, 8'(opnd_lo + idx_x)};
                            13: e_ea = {8'h00, 8'(opnd_lo + idx_y)};
                            5:  begin e_immv = 1; e_imm = opnd_lo; end
                            default: e_bad = 1;
                        endcase
                        ph = 4;
                    end
                end
                1: ph = 2;
                2: ph = 3;
                3: begin e_ea = pend; e_immv = 0; e_bad = 0; e_imm = '0; ph = 4; end
                default: ph = 0;
            endcase
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!finished) begin
            cycles++;
            if (cycles > WATCHDOG) begin
                fails++;
                $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
                $display("  test done: total=%0d bad=%0d", checks, fails);
                finished = 1;
                $finish;
            end
            if (!rst_n) begin
                chk("R10", "busy", busy, 0);
                chk("R10", "done", done, 0);
                chk("R10", "mem_rd", mem_rd, 0);
                chk("R10", "mem_addr", mem_addr, 0);
                chk("R10", "ea", ea, 0);
                chk("R10", "imm_valid", imm_valid, 0);
                chk("R10", "imm_val", imm_val, 0);
                chk("R10", "bad_mode", bad_mode, 0);
            end else begin
                chk("R9", "busy", busy, ph != 0);
                chk("R9", "done", done, ph == 4);
                chk(cur_req, "mem_rd", mem_rd, (ph == 1 || ph == 2));
                if (ph == 1) chk(cur_req, "mem_addr lo", mem_addr, e_ptr);
                if (ph == 2) chk(cur_req, "mem_addr hi", mem_addr, 16'(e_ptr + 16'd1));
                chk(cur_req, "ea", ea, e_ea);
                chk(cur_req, "imm_valid", imm_valid, e_immv);
                chk(cur_req, "imm_val", imm_val, e_imm);
                chk(cur_req, "bad_mode", bad_mode, e_bad);
            end
        end
    end

    task automatic issue(input int m, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] x, input logic [7:0] y);
        @(negedge clk);
        mode = 4'(m); opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: length per code, start low
        for (int m = 0; m < 16; m++) begin
            mode = 4'(m);
            #1;
            chk("R1", "inst_len", inst_len, len_of(m));
            @(negedge clk);
        end
        // R2
        issue(1, 8'h34, 8'h12, 8'h00, 8'h00);
        issue(2, 8'hFF, 8'h12, 8'h01, 8'h00);
        issue(3, 8'hFF, 8'hFF, 8'h00, 8'h02);
        // R3
        issue(11, 8'h80, 8'h55, 8'h00, 8'h00);
        issue(12, 8'hF0, 8'h55, 8'h20, 8'h00);
        issue(13, 8'h7F, 8'h55, 8'h00, 8'h01);
        // R4
        issue(5, 8'h9C, 8'h11, 8'h00, 8'h00);
        // R5
        issue(0, 8'h01, 8'h02, 8'h03, 8'h04);
        issue(4, 8'h01, 8'h02, 8'h03, 8'h04);
        issue(6, 8'h01, 8'h02, 8'h03, 8'h04);
        issue(10, 8'h01, 8'h02, 8'h03, 8'h04);
        issue(15, 8'h01, 8'h02, 8'h03, 8'h04);
        // R6
        issue(7, 8'hFF, 8'h30, 8'h00, 8'h00);
        issue(7, 8'hFF, 8'hFF, 8'h00, 8'h00);
        // R7
        issue(8, 8'h10, 8'h99, 8'h05, 8'h00);
        issue(8, 8'hF0, 8'h99, 8'h0F, 8'h00);
        // R8
        issue(9, 8'h40, 8'h99, 8'h00, 8'hFF);
        issue(9, 8'hFF, 8'h99, 8'h00, 8'h10);
        // R9: start while busy is ignored
        @(negedge clk);
        mode = 4'd7; opnd_lo = 8'h21; opnd_hi = 8'h43; idx_x = 8'h00; idx_y = 8'h00;
        start = 1'b1;
        @(negedge clk);
        mode = 4'd5; opnd_lo = 8'hEE;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        issue(2, 8'h00, 8'h80, 8'hAA, 8'h00);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule